// File: doc/BRIEF.md
# Endian-Aware Peripheral Register Decoder

This block sits between a CPU's request path and a small set of peripheral registers that live in a 16 KB internal address window. Each cycle it may take one request made up of a 32-bit address, a transfer size (byte, half-word or word), write data, a write flag and an endianness mode bit. It works out whether the address is internal and which 64-byte register slot it hits. It then steers byte lanes for the GPIO ports, updates the selected register and returns a registered response one cycle later.

The register set has two parts. The first is a bank of four byte-wide GPIO ports that share one slot and answer to individual byte addresses or to a single word access. The second is a group of word registers that ignore the low six address bits: a control register, a configuration register, a time-count register and a time-alarm register. The two time registers keep their contents through a user reset or a power-fail reset and clear only on power-on reset. Any request outside the window, and any internal request while debug mode is on, raises a flag telling the external bus to run a cycle.

Slot map, with the offset taken from address bits 13:6 inside the window: slot 0 holds the ports, slot 1 the control register (bits 15:0 defined), slot 2 is an unused gap, slot 3 holds the configuration register, slot 4 the time count and slot 5 the time alarm. Sizes are encoded as 2'b00 byte, 2'b01 half-word and 2'b1x word.

Top module: `perireg_decoder`

## Requirements
- R1: An address whose bits 31:14 equal 18'h20000 (0x8000_0000 to 0x8000_3FFF) is internal and sets `rsp_internal`. It raises `ext_start` only when `debug_en` is high. Any other address raises `ext_start`, changes no register and reads zero.
- R2: A word register answers at every address in its 64-byte slot, so address bits 5:0 have no effect on which register is selected.
- R3: In slot 0 with little-endian mode, a byte access at offset n (address bits 1:0) reaches port n. The written byte is taken from write data lane n (bits 8n+7:8n). A byte read returns port n on lane n with every other lane zero.
- R4: With `big_endian` high, a byte access to slot 0 at offset n reaches port 3−n, and the data uses that port's lane.
- R5: A word access to slot 0 reads or writes all four ports at once, with port A on bits 7:0 through port D on bits 31:24. The result is the same in both endianness modes.
- R6: Word registers ignore the transfer size. A byte read returns the whole register, and a byte write writes the whole register from all 32 write data bits.
- R7: A half-word access to slot 0 writes nothing, reads zero and raises `rsp_err` for exactly the response cycle of that request.
- R8: Writes to undefined bits (control bits 31:16) or to undefined slots have no effect, and reads of either return zero. The gap in slot 2 does not widen a neighbouring register's alias range.
- R9: A low level on `rst_user_n` or `rst_pwrfail_n` clears the ports, control and configuration registers. The time count and time alarm registers keep their values.
- R10: A low level on `rst_por_n` clears every register, including the two time registers, and the response outputs.
- R11: Every request is answered on the next clock edge: `rsp_valid` is high in the cycle after `req_valid` and low otherwise. A write becomes visible to a read issued in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_por_n | input | 1 | Power-on reset, active low, clears all registers |
| rst_user_n | input | 1 | User reset, active low, spares the time registers |
| rst_pwrfail_n | input | 1 | Power-fail reset, active low, spares the time registers |
| debug_en | input | 1 | Debug mode: internal accesses also start an external cycle |
| big_endian | input | 1 | Endianness mode for port byte addressing |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 32 | Byte address |
| req_size | input | 2 | Transfer size: 00 byte, 01 half-word, 1x word |
| req_wdata | input | 32 | Write data, least significant byte on bits 7:0 |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data |
| rsp_internal | output | 1 | The previous request hit the internal window |
| ext_start | output | 1 | The previous request must run on the external bus |
| rsp_err | output | 1 | The previous request was a half-word access to the ports |

## Verification
The hardest case to reach is the interaction between the endianness bit and the port lanes. A byte written in big-endian mode has to be read back in the other mode, and as a word, to show which physical port it reached. The bench fills all four ports with distinct bytes, overwrites one of them through a reversed byte address, and reads the bank back as a little-endian word. The split reset is reached the same way: the time registers and ordinary registers are loaded with known values, each reset line is pulsed alone, and every register is read back over the bus.

// File: rtl/perireg_pkg.sv
package perireg_pkg;

    // Data path geometry
    localparam int PORT_CNT = 4;
    localparam int PORT_W   = 8;
    localparam int DATA_W   = PORT_CNT * PORT_W;
    localparam int ADDR_W   = 32;

    // Internal window: 16 KB, tagged by the upper address bits
    localparam int WIN_LSB  = 14;
    localparam int TAG_W    = ADDR_W - WIN_LSB;
    localparam logic [TAG_W-1:0] WIN_TAG = 18'h20000;

    // Register slots of 64 bytes each
    localparam int SLOT_LSB = 6;
    localparam int SLOT_W   = WIN_LSB - SLOT_LSB;
    localparam logic [SLOT_W-1:0] SLOT_PORTS = 8'd0;
    localparam logic [SLOT_W-1:0] SLOT_CTRL  = 8'd1;
    localparam logic [SLOT_W-1:0] SLOT_GAP   = 8'd2;
    localparam logic [SLOT_W-1:0] SLOT_CFG   = 8'd3;
    localparam logic [SLOT_W-1:0] SLOT_TIME  = 8'd4;
    localparam logic [SLOT_W-1:0] SLOT_ALARM = 8'd5;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_HALF  = 2'b01,
        SZ_WORD  = 2'b10,
        SZ_WORDX = 2'b11
    } size_e;

    typedef struct packed {
        logic              hit_int;
        logic [SLOT_W-1:0] slot;
        logic              is_port;
        logic [1:0]        port_idx;
        logic              is_half;
        logic              is_word;
    } dec_t;

    typedef struct packed {
        logic              valid;
        logic              internal;
        logic              ext;
        logic              err;
        logic [DATA_W-1:0] rdata;
    } rsp_t;

endpackage

// File: rtl/perireg_addr_decode.sv
module perireg_addr_decode
    import perireg_pkg::*;
(
    input  logic [TAG_W-1:0]  addr_tag,
    input  logic [SLOT_W-1:0] addr_slot,
    input  logic [1:0]        addr_byte,
    input  logic [1:0]        size,
    input  logic              big_endian,
    output dec_t              dec
);

    always_comb begin
        dec          = '0;
        dec.hit_int  = (addr_tag == WIN_TAG);
        dec.slot     = addr_slot;
        dec.is_port  = dec.hit_int && (addr_slot == SLOT_PORTS);
        // Reversed byte address in big-endian mode: n -> 3-n
        dec.port_idx = big_endian ? ~addr_byte : addr_byte;
        dec.is_half  = (size == SZ_HALF);
        dec.is_word  = size[1];
    end

endmodule

// File: rtl/perireg_port_bank.sv
module perireg_port_bank #(
    parameter int PORTS = 4,
    parameter int PW    = 8,
    localparam int BW   = PORTS * PW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PORTS-1:0] we,
    input  logic [BW-1:0]    wdata,
    output logic [BW-1:0]    q
);

    logic [PORTS-1:0][PW-1:0] port_d, port_q;

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        always_comb begin
            port_d[p] = port_q[p];
            if (we[p]) begin
                port_d[p] = wdata[p*PW +: PW];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            port_q <= '0;
        end else begin
            port_q <= port_d;
        end
    end

    assign q = port_q;

endmodule

// File: rtl/perireg_word_reg.sv
module perireg_word_reg #(
    parameter int          W    = 32,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    logic [W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (we) begin
            val_d = wdata & MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q <= '0;
        end else begin
            val_q <= val_d;
        end
    end

    assign q = val_q;

endmodule

// File: rtl/perireg_decoder.sv
module perireg_decoder
    import perireg_pkg::*;
#(
    parameter logic [31:0] CTRL_MASK = 32'h0000_FFFF,
    parameter logic [31:0] CFG_MASK  = 32'hFFFF_FFFF,
    parameter logic [31:0] TIME_MASK = 32'hFFFF_FFFF
) (
    input  logic        clk,
    input  logic        rst_por_n,
    input  logic        rst_user_n,
    input  logic        rst_pwrfail_n,
    input  logic        debug_en,
    input  logic        big_endian,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [31:0] req_addr,
    input  logic [1:0]  req_size,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic        rsp_internal,
    output logic        ext_start,
    output logic        rsp_err
);

    localparam int N_WREG = 4;
    localparam logic [N_WREG-1:0][SLOT_W-1:0] WREG_SLOT =
        {SLOT_ALARM, SLOT_TIME, SLOT_CFG, SLOT_CTRL};
    localparam logic [N_WREG-1:0][DATA_W-1:0] WREG_MASK =
        {TIME_MASK, TIME_MASK, CFG_MASK, CTRL_MASK};
    localparam logic [N_WREG-1:0] WREG_POR_ONLY = 4'b1100;
    localparam logic [DATA_W-1:0] LANE0_MASK =
        {{(DATA_W-PORT_W){1'b0}}, {PORT_W{1'b1}}};

    // Any of the three resets clears the ordinary registers
    logic sys_rst_n;
    assign sys_rst_n = rst_por_n & rst_user_n & rst_pwrfail_n;

    // Offset bits inside a slot take no part in word register selection
    logic unused_addr_bits;
    assign unused_addr_bits = ^req_addr[SLOT_LSB-1:2];

    dec_t dec;

    perireg_addr_decode u_dec (
        .addr_tag   (req_addr[ADDR_W-1:WIN_LSB]),
        .addr_slot  (req_addr[WIN_LSB-1:SLOT_LSB]),
        .addr_byte  (req_addr[1:0]),
        .size       (req_size),
        .big_endian (big_endian),
        .dec        (dec)
    );

    logic                             wr_ok;
    logic [PORT_CNT-1:0]              port_we;
    logic [DATA_W-1:0]                port_q;
    logic [N_WREG-1:0]                wreg_we;
    logic [N_WREG-1:0][DATA_W-1:0]    wreg_q;
    logic [DATA_W-1:0]                rd_word;
    logic [DATA_W-1:0]                lane_mask;
    rsp_t                             rsp_d, rsp_q;

    // Write enables and read selection
    always_comb begin
        wr_ok     = req_valid && req_write && dec.hit_int;
        port_we   = '0;
        wreg_we   = '0;
        rd_word   = '0;
        lane_mask = LANE0_MASK << (PORT_W * dec.port_idx);

        if (dec.is_port) begin
            if (dec.is_word) begin
                port_we = {PORT_CNT{wr_ok}};
                rd_word = port_q;
            end else if (!dec.is_half) begin
                port_we = {{(PORT_CNT-1){1'b0}}, wr_ok} << dec.port_idx;
                rd_word = port_q & lane_mask;
            end
        end

        for (int i = 0; i < N_WREG; i++) begin
            if (dec.hit_int && (dec.slot == WREG_SLOT[i])) begin
                wreg_we[i] = wr_ok;
                rd_word    = wreg_q[i];
            end
        end
    end

    perireg_port_bank #(
        .PORTS (PORT_CNT),
        .PW    (PORT_W)
    ) u_ports (
        .clk   (clk),
        .rst_n (sys_rst_n),
        .we    (port_we),
        .wdata (req_wdata),
        .q     (port_q)
    );

    for (genvar g = 0; g < N_WREG; g++) begin : g_wreg
        perireg_word_reg #(
            .W    (DATA_W),
            .MASK (WREG_MASK[g])
        ) u_reg (
            .clk   (clk),
            .rst_n (WREG_POR_ONLY[g] ? rst_por_n : sys_rst_n),
            .we    (wreg_we[g]),
            .wdata (req_wdata),
            .q     (wreg_q[g])
        );
    end

    // Response next-state
    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = req_valid;
        if (req_valid) begin
            rsp_d.internal = dec.hit_int;
            rsp_d.ext      = !dec.hit_int || debug_en;
            rsp_d.err      = dec.is_port && dec.is_half;
            if (dec.hit_int && !req_write) begin
                rsp_d.rdata = rd_word;
            end
        end
    end

    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid    = rsp_q.valid;
    assign rsp_rdata    = rsp_q.rdata;
    assign rsp_internal = rsp_q.internal;
    assign ext_start    = rsp_q.ext;
    assign rsp_err      = rsp_q.err;

endmodule

// File: rtl/perireg_chk.sv
module perireg_chk
    import perireg_pkg::*;
(
    input logic        clk,
    input logic        rst_por_n,
    input logic        rst_user_n,
    input logic        rst_pwrfail_n,
    input logic        debug_en,
    input logic        req_valid,
    input logic [31:0] req_addr,
    input logic [1:0]  req_size,
    input logic        rsp_valid,
    input logic [31:0] rsp_rdata,
    input logic        rsp_internal,
    input logic        ext_start,
    input logic        rsp_err
);

    logic any_rst;
    logic in_win;
    assign any_rst = !(rst_por_n && rst_user_n && rst_pwrfail_n);
    assign in_win  = (req_addr[31:14] == WIN_TAG);

    // R1
    int_no_ext_chk: assert property (@(posedge clk) disable iff (any_rst)
        (req_valid && in_win && !debug_en) |=> (rsp_internal && !ext_start));

    // R1
    outside_ext_chk: assert property (@(posedge clk) disable iff (any_rst)
        (req_valid && !in_win) |=> (ext_start && !rsp_internal && rsp_rdata == 32'h0));

    // R7
    half_port_err_chk: assert property (@(posedge clk) disable iff (any_rst)
        (req_valid && in_win && req_addr[13:6] == SLOT_PORTS && req_size == SZ_HALF)
        |=> (rsp_err && rsp_rdata == 32'h0));

    // R7
    err_one_cycle_chk: assert property (@(posedge clk) disable iff (any_rst)
        !req_valid |=> !rsp_err);

    // R11
    rsp_follow_chk: assert property (@(posedge clk) disable iff (any_rst)
        req_valid |=> rsp_valid);

    // R11
    rsp_idle_chk: assert property (@(posedge clk) disable iff (any_rst)
        !req_valid |=> (!rsp_valid && !ext_start && !rsp_internal));

endmodule

bind perireg_decoder perireg_chk u_chk (
    .clk           (clk),
    .rst_por_n     (rst_por_n),
    .rst_user_n    (rst_user_n),
    .rst_pwrfail_n (rst_pwrfail_n),
    .debug_en      (debug_en),
    .req_valid     (req_valid),
    .req_addr      (req_addr),
    .req_size      (req_size),
    .rsp_valid     (rsp_valid),
    .rsp_rdata     (rsp_rdata),
    .rsp_internal  (rsp_internal),
    .ext_start     (ext_start),
    .rsp_err       (rsp_err)
);

// File: tb/tb_perireg_decoder.sv
module tb_perireg_decoder;

    logic        clk = 1'b0;
    logic        rst_por_n = 1'b0;
    logic        rst_user_n = 1'b0;
    logic        rst_pwrfail_n = 1'b0;
    logic        debug_en = 1'b0;
    logic        big_endian = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = 2'b10;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_internal;
    logic        ext_start;
    logic        rsp_err;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] c_rdata;
    logic        c_valid, c_int, c_ext, c_err;

    localparam logic [1:0] B = 2'b00, H = 2'b01, W = 2'b10;
    localparam logic [31:0] A_PORT  = 32'h8000_0000;
    localparam logic [31:0] A_CTRL  = 32'h8000_0040;
    localparam logic [31:0] A_GAP   = 32'h8000_0080;
    localparam logic [31:0] A_CFG   = 32'h8000_00C0;
    localparam logic [31:0] A_TIME  = 32'h8000_0100;
    localparam logic [31:0] A_ALARM = 32'h8000_0140;

    always #10 clk = ~clk;

    perireg_decoder dut (
        .clk           (clk),
        .rst_por_n     (rst_por_n),
        .rst_user_n    (rst_user_n),
        .rst_pwrfail_n (rst_pwrfail_n),
        .debug_en      (debug_en),
        .big_endian    (big_endian),
        .req_valid     (req_valid),
        .req_write     (req_write),
        .req_addr      (req_addr),
        .req_size      (req_size),
        .req_wdata     (req_wdata),
        .rsp_valid     (rsp_valid),
        .rsp_rdata     (rsp_rdata),
        .rsp_internal  (rsp_internal),
        .ext_start     (ext_start),
        .rsp_err       (rsp_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // One request, response captured one edge later
    task automatic xfer(input logic w, input logic [31:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, input logic be);
        @(negedge clk);
        req_valid  = 1'b1;
        req_write  = w;
        req_addr   = a;
        req_size   = sz;
        req_wdata  = wd;
        big_endian = be;
        @(negedge clk);
        c_rdata = rsp_rdata;
        c_valid = rsp_valid;
        c_int   = rsp_internal;
        c_ext   = ext_start;
        c_err   = rsp_err;
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [31:0] a, input logic [1:0] sz,
                            input logic be, input logic [31:0] exp);
        xfer(1'b0, a, sz, 32'h0, be);
        check(req, c_rdata, exp);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R10 idle valid", {31'h0, rsp_valid}, 32'h0);
        check("R10 idle ext", {31'h0, ext_start}, 32'h0);
        rd_check("R10 ports clear", A_PORT, W, 1'b0, 32'h0);
        check("R11 valid after request", {31'h0, c_valid}, 32'h1);
        rd_check("R10 ctrl clear", A_CTRL, W, 1'b0, 32'h0);
        rd_check("R10 time clear", A_TIME, W, 1'b0, 32'h0);
        @(negedge clk);
        check("R11 valid drops", {31'h0, rsp_valid}, 32'h0);
    endtask

    task automatic t_le_bytes;
        xfer(1'b1, A_PORT | 32'h0, B, 32'h0000_00A1, 1'b0);
        xfer(1'b1, A_PORT | 32'h1, B, 32'h0000_B200, 1'b0);
        xfer(1'b1, A_PORT | 32'h2, B, 32'h00C3_0000, 1'b0);
        xfer(1'b1, A_PORT | 32'h3, B, 32'hD400_0000, 1'b0);
        rd_check("R3 R5 ports as word", A_PORT, W, 1'b0, 32'hD4C3_B2A1);
        rd_check("R3 byte read lane 2", A_PORT | 32'h2, B, 1'b0, 32'h00C3_0000);
    endtask

    task automatic t_big_endian;
        xfer(1'b1, A_PORT, B, 32'h5A00_0000, 1'b1);
        rd_check("R4 BE byte 0 hits port D", A_PORT, W, 1'b0, 32'h5AC3_B2A1);
        rd_check("R4 BE byte 3 reads port A", A_PORT | 32'h3, B, 1'b1, 32'h0000_00A1);
        xfer(1'b1, A_PORT, W, 32'h1122_3344, 1'b1);
        rd_check("R5 BE word write, LE read", A_PORT, W, 1'b0, 32'h1122_3344);
        rd_check("R5 BE word read", A_PORT, W, 1'b1, 32'h1122_3344);
    endtask

    task automatic t_alias_size;
        xfer(1'b1, A_CFG | 32'h3C, W, 32'hCAFE_F00D, 1'b0);
        rd_check("R2 alias read", A_CFG | 32'h4, W, 1'b0, 32'hCAFE_F00D);
        rd_check("R6 byte read whole word", A_CFG | 32'h1, B, 1'b1, 32'hCAFE_F00D);
        xfer(1'b1, A_CFG | 32'h2, B, 32'h1234_5678, 1'b0);
        rd_check("R6 byte write whole word", A_CFG, W, 1'b0, 32'h1234_5678);
    endtask

    task automatic t_undefined;
        xfer(1'b1, A_CTRL | 32'h3C, W, 32'hFFFF_FFFF, 1'b0);
        rd_check("R8 ctrl undefined bits", A_CTRL, W, 1'b0, 32'h0000_FFFF);
        xfer(1'b1, A_GAP, W, 32'h0BAD_0BAD, 1'b0);
        xfer(1'b1, A_GAP | 32'h3C, W, 32'h0BAD_0BAD, 1'b0);
        rd_check("R8 gap reads zero", A_GAP | 32'h8, W, 1'b0, 32'h0);
        rd_check("R8 ctrl untouched by gap", A_CTRL, W, 1'b0, 32'h0000_FFFF);
        rd_check("R8 cfg untouched by gap", A_CFG, W, 1'b0, 32'h1234_5678);
        xfer(1'b1, 32'h8000_3FC0, W, 32'hFFFF_FFFF, 1'b0);
        rd_check("R8 unmapped slot zero", 32'h8000_3FC0, W, 1'b0, 32'h0);
    endtask

    task automatic t_half;
        xfer(1'b1, A_PORT, H, 32'h0, 1'b0);
        check("R7 half write err", {31'h0, c_err}, 32'h1);
        rd_check("R7 ports unchanged", A_PORT, W, 1'b0, 32'h1122_3344);
        check("R7 no err on word", {31'h0, c_err}, 32'h0);
        xfer(1'b0, A_PORT | 32'h2, H, 32'h0, 1'b0);
        check("R7 half read zero", c_rdata, 32'h0);
        check("R7 half read err", {31'h0, c_err}, 32'h1);
        @(negedge clk);
        check("R7 err one cycle", {31'h0, rsp_err}, 32'h0);
    endtask

    task automatic t_external;
        xfer(1'b0, 32'h0000_1000, W, 32'h0, 1'b0);
        check("R1 outside ext_start", {31'h0, c_ext}, 32'h1);
        check("R1 outside not internal", {31'h0, c_int}, 32'h0);
        check("R1 outside reads zero", c_rdata, 32'h0);
        xfer(1'b1, 32'h8000_4000, W, 32'hFFFF_FFFF, 1'b0);
        check("R1 just above window ext", {31'h0, c_ext}, 32'h1);
        rd_check("R1 outside write no effect", A_PORT, W, 1'b0, 32'h1122_3344);
        check("R1 internal no ext", {31'h0, c_ext}, 32'h0);
        check("R1 internal flag", {31'h0, c_int}, 32'h1);
        debug_en = 1'b1;
        rd_check("R1 debug read data", A_CFG, W, 1'b0, 32'h1234_5678);
        check("R1 debug ext_start", {31'h0, c_ext}, 32'h1);
        check("R1 debug internal", {31'h0, c_int}, 32'h1);
        debug_en = 1'b0;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: rst_por_n = 1'b0;
            1: rst_user_n = 1'b0;
            default: rst_pwrfail_n = 1'b0;
        endcase
        @(negedge clk);
        rst_por_n = 1'b1;
        rst_user_n = 1'b1;
        rst_pwrfail_n = 1'b1;
    endtask

    task automatic t_reset_domains;
        xfer(1'b1, A_TIME, W, 32'h00AB_CDEF, 1'b0);
        xfer(1'b1, A_ALARM | 32'h20, W, 32'h0000_0777, 1'b0);
        pulse(1);
        rd_check("R9 user clears ports", A_PORT, W, 1'b0, 32'h0);
        rd_check("R9 user clears ctrl", A_CTRL, W, 1'b0, 32'h0);
        rd_check("R9 user clears cfg", A_CFG, W, 1'b0, 32'h0);
        rd_check("R9 user keeps time", A_TIME, W, 1'b0, 32'h00AB_CDEF);
        rd_check("R9 user keeps alarm", A_ALARM, W, 1'b0, 32'h0000_0777);
        xfer(1'b1, A_CFG, W, 32'h0000_0001, 1'b0);
        pulse(2);
        rd_check("R9 pwrfail clears cfg", A_CFG, W, 1'b0, 32'h0);
        rd_check("R9 pwrfail keeps time", A_TIME, W, 1'b0, 32'h00AB_CDEF);
        pulse(0);
        rd_check("R10 por clears time", A_TIME, W, 1'b0, 32'h0);
        rd_check("R10 por clears alarm", A_ALARM, W, 1'b0, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_por_n = 1'b1;
        rst_user_n = 1'b1;
        rst_pwrfail_n = 1'b1;
        t_reset();
        t_le_bytes();
        t_big_endian();
        t_alias_size();
        t_undefined();
        t_half();
        t_external();
        t_reset_domains();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule